// File: doc/BRIEF.md
# PCI Configuration and I/O Target

This block is a minimal 32-bit PCI bus target. It watches the multiplexed address/data bus for the start of a transaction, captures the address, the command and the device-select line in the address phase, and claims the cycle when the command and the address are meant for it. It answers configuration reads from a fixed 16-byte header. It takes configuration writes, but the only bit it keeps is the I/O-enable bit of the command register. It also answers single-word I/O reads and writes to one register at a fixed I/O address. Bit 0 of that register drives an LED output.

The bus pins are split into plain inputs and outputs. The address/data lines appear as `ad_in`, `ad_out` and `ad_oe`, so that a pad ring can build the tri-state drivers. The block launches its handshake outputs and its read data on the falling clock edge, and the host samples them on the next rising edge. PCI has no valid/ready interface. Back-pressure is the PCI rule itself: a word moves only on a rising edge where both IRDY# and TRDY# are low. While IRDY# stays high, the block holds its outputs. Each transaction moves exactly one data word.

Top module: `pci_cfg_io_target`

## Requirements
- R1: After reset, `devsel_n` and `trdy_n` are high, `ad_oe` is 0, `led` is 0 and I/O decoding is disabled.
- R2: A configuration read has IDSEL high, command 0xA and AD[1:0]=0. DWORD index AD[7:2] 0 to 3 returns these values: {device ID, vendor ID}; {16'h0000 status, command register with bit 0 = I/O enable}; {24-bit class code, revision}; {BIST, header type, latency timer, cache line size}.
- R3: A configuration read to DWORD index 4 or higher is claimed and returns zero.
- R4: A configuration command with IDSEL low, or with AD[1:0] not zero, is not claimed: `devsel_n` stays high.
- R5: A configuration write has IDSEL high and command 0xB. Written to DWORD 1 with C/BE#[0] low in the data phase, it stores AD[0] as the I/O-enable bit. The write is claimed and completed at any DWORD index.
- R6: While I/O enable is 0, I/O commands are not claimed.
- R7: An I/O write has command 0x3 to address IO_BASE (default 0x2000). It stores the data word on the rising edge where IRDY# and TRDY# are both low. `led` takes bit 0 of the word on the following rising edge.
- R8: An I/O read has command 0x2 to IO_BASE. It returns the stored word with `ad_oe` high.
- R9: An I/O access to any other address, and any command other than 0x2, 0x3, 0xA or 0xB, is not claimed and leaves the I/O register unchanged.
- R10: The data phase waits while IRDY# is high. During the wait, TRDY# and DEVSEL# stay low and the read data stays stable.
- R11: DEVSEL#, TRDY#, `ad_oe` and `ad_out` change only on falling edges. They are first asserted on the falling edge that follows the address phase.
- R12: On the falling edge after the data transfer, DEVSEL# and TRDY# go high and `ad_oe` goes to 0. The block is idle again on the first rising edge that sees FRAME# high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | FRAME#, transaction in progress |
| irdy_n | input | 1 | IRDY#, initiator ready |
| idsel | input | 1 | Configuration device select |
| cbe_n | input | 4 | Command in the address phase, byte enables in the data phase |
| ad_in | input | 32 | Address/data lines as seen from the bus |
| ad_out | output | 32 | Read data toward the bus |
| ad_oe | output | 1 | Output enable for the AD drivers |
| devsel_n | output | 1 | DEVSEL#, transaction claimed |
| trdy_n | output | 1 | TRDY#, target ready |
| led | output | 1 | Bit 0 of the I/O register, one clock late |

## Verification
The embedded properties cover the handshake relations that must hold on every edge. While IRDY# is high, TRDY# is held low. After a transfer, both handshakes are released and the drivers turn off. The AD drivers are only ever on during a claimed read. No I/O cycle is claimed while I/O is disabled. The LED follows the written bit two edges after the transfer. The data values need the directed scenarios: header contents, zero beyond the header, the effect of the enable bit, and that a mismatched address or command leaves the register untouched. Falling-edge launch timing also needs the scenarios, which sample between the edges.

// File: rtl/pcit_pkg.sv
package pcit_pkg;
  localparam int unsigned AW = 32;

  typedef enum logic [3:0] {
    CMD_IO_RD  = 4'h2,
    CMD_IO_WR  = 4'h3,
    CMD_CFG_RD = 4'hA,
    CMD_CFG_WR = 4'hB
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_SKIP,
    ST_TURN
  } tgt_state_e;
endpackage

// File: rtl/pcit_decode.sv
module pcit_decode
  import pcit_pkg::*;
#(
  parameter logic [31:0] IO_BASE = 32'h0000_2000
) (
  input  logic [31:0] addr,
  input  logic [3:0]  cmd,
  input  logic        sel,
  input  logic        io_en,
  output logic        hit,
  output logic        is_cfg,
  output logic        is_read
);
  logic cfg_cmd, io_cmd;

  always_comb begin
    cfg_cmd = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
    io_cmd  = (cmd == CMD_IO_RD)  || (cmd == CMD_IO_WR);
    is_cfg  = cfg_cmd;
    is_read = (cmd == CMD_CFG_RD) || (cmd == CMD_IO_RD);
    hit     = (cfg_cmd && sel && (addr[1:0] == 2'b00)) ||
              (io_cmd && !sel && io_en && (addr == IO_BASE));
  end
endmodule

// File: rtl/pcit_header.sv
module pcit_header #(
  parameter logic [15:0] VENDOR_ID = 16'hF0C5,
  parameter logic [15:0] DEVICE_ID = 16'h0C1A,
  parameter logic [23:0] CLASS     = 24'h078000,
  parameter logic [7:0]  REV       = 8'h01,
  parameter logic [7:0]  HDR_TYPE  = 8'h00,
  parameter logic [7:0]  LAT_TMR   = 8'h10,
  parameter logic [7:0]  LINE_SZ   = 8'h08,
  parameter int unsigned IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [IDX_W-1:0] idx,
  input  logic             be0_n,
  input  logic             wbit,
  output logic [31:0]      rdata,
  output logic             io_en
);
  localparam int unsigned LAST_IDX = 3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) io_en <= 1'b0;
    else if (wr_stb && idx == IDX_W'(1) && !be0_n) io_en <= wbit;
  end

  always_comb begin
    rdata = '0;
    if (idx <= IDX_W'(LAST_IDX)) begin
      case (idx[1:0])
        2'd0: rdata = {DEVICE_ID, VENDOR_ID};
        2'd1: rdata = {16'h0000, 15'd0, io_en};
        2'd2: rdata = {CLASS, REV};
        default: rdata = {8'h00, HDR_TYPE, LAT_TMR, LINE_SZ};
      endcase
    end
  end
endmodule

// File: rtl/pci_cfg_io_target.sv
module pci_cfg_io_target
  import pcit_pkg::*;
#(
  parameter logic [31:0] IO_BASE   = 32'h0000_2000,
  parameter logic [15:0] VENDOR_ID = 16'hF0C5,
  parameter logic [15:0] DEVICE_ID = 16'h0C1A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        led
);
  localparam int unsigned IDX_W = 6;

  tgt_state_e state;
  logic [31:0] addr_q, io_reg, hdr_rdata, rdata;
  logic [3:0]  cmd_q;
  logic        cfg_q, rd_q;
  logic        hit, is_cfg, is_read, io_en, xfer;

  pcit_decode #(.IO_BASE(IO_BASE)) u_dec (
    .addr(ad_in), .cmd(cbe_n), .sel(idsel), .io_en(io_en),
    .hit(hit), .is_cfg(is_cfg), .is_read(is_read)
  );

  assign xfer = (state == ST_DATA) && !irdy_n;

  pcit_header #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .IDX_W(IDX_W)) u_hdr (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(xfer && cfg_q && !rd_q),
    .idx(addr_q[IDX_W+1:2]), .be0_n(cbe_n[0]), .wbit(ad_in[0]),
    .rdata(hdr_rdata), .io_en(io_en)
  );

  assign rdata = cfg_q ? hdr_rdata : io_reg;

  // Rising-edge sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      cmd_q  <= '0;
      cfg_q  <= 1'b0;
      rd_q   <= 1'b0;
      io_reg <= '0;
      led    <= 1'b0;
    end else begin
      led <= io_reg[0];
      case (state)
        ST_IDLE: if (!frame_n) begin
          addr_q <= ad_in;
          cmd_q  <= cbe_n;
          cfg_q  <= is_cfg;
          rd_q   <= is_read;
          state  <= hit ? ST_DATA : ST_SKIP;
        end
        ST_DATA: if (!irdy_n) begin
          if (!cfg_q && !rd_q) io_reg <= ad_in;
          state <= frame_n ? ST_IDLE : ST_TURN;
        end
        ST_SKIP: if (frame_n && irdy_n) state <= ST_IDLE;
        default: if (frame_n) state <= ST_IDLE;
      endcase
    end
  end

  // Falling-edge launch of handshakes and read data
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      ad_oe    <= 1'b0;
      ad_out   <= '0;
    end else begin
      devsel_n <= (state != ST_DATA);
      trdy_n   <= (state != ST_DATA);
      ad_oe    <= (state == ST_DATA) && rd_q;
      ad_out   <= ((state == ST_DATA) && rd_q) ? rdata : '0;
    end
  end

  // R8
  oe_only_claimed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!devsel_n && !cmd_q[0]));
  // R10
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> (!trdy_n && !devsel_n && $stable(ad_out)));
  // R12
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n) |=> (trdy_n && devsel_n && !ad_oe));
  // R6
  io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(devsel_n) && !io_en) |-> cfg_q);
  // R7
  led_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !irdy_n && !devsel_n && cmd_q == CMD_IO_WR) |-> ##2 (led == $past(ad_in[0], 2)));
endmodule

// File: tb/pci_cfg_io_target_tb.sv
`timescale 1ns/1ps
module pci_cfg_io_target_tb;
  logic clk = 0, rst_n = 0;
  logic frame_n = 1, irdy_n = 1, idsel = 0;
  logic [3:0] cbe_n = 4'hF;
  logic [31:0] ad_in = '0, ad_out;
  logic ad_oe, devsel_n, trdy_n, led;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pci_cfg_io_target u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .led(led)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One single-word transaction; returns claim flag and read data.
  task automatic bus(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                     input logic [31:0] wdata, input int waits, input logic [3:0] be,
                     output logic claimed, output logic [31:0] rdata);
    int w = waits;
    claimed = 0; rdata = 'x;
    @(posedge clk); #1;
    frame_n = 0; ad_in = addr; cbe_n = cmd; idsel = sel;
    @(posedge clk); #1;
    frame_n = 1; idsel = 0; cbe_n = be; ad_in = wdata; irdy_n = (w > 0);
    check("R11 devsel before falling edge", devsel_n, 1'b1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      if (!devsel_n && !irdy_n) begin
        claimed = 1; rdata = ad_out;
        @(posedge clk); #1; irdy_n = 1; ad_in = '0;
        @(negedge clk); #1;
        check("R12 release devsel", devsel_n, 1'b1);
        check("R12 release trdy", trdy_n, 1'b1);
        check("R12 release oe", ad_oe, 1'b0);
        return;
      end
      if (!devsel_n && w > 0) check("R10 trdy held in wait", trdy_n, 1'b0);
      if (devsel_n && i >= 3) begin
        @(posedge clk); #1; irdy_n = 1; ad_in = '0;
        @(negedge clk); #1;
        return;
      end
      @(posedge clk); #1;
      if (w > 0) begin w--; if (w == 0) irdy_n = 0; end
      else if (devsel_n) irdy_n = 0;
    end
  endtask

  task automatic t_reset();
    check("R1 devsel", devsel_n, 1); check("R1 trdy", trdy_n, 1);
    check("R1 oe", ad_oe, 0); check("R1 led", led, 0);
  endtask

  task automatic t_header();
    logic c; logic [31:0] d;
    bus(4'hA, 32'h0, 1, 0, 0, 4'h0, c, d); check("R2 dw0 claim", c, 1); check("R2 dw0", d, 32'h0C1AF0C5);
    bus(4'hA, 32'h4, 1, 0, 0, 4'h0, c, d); check("R2 dw1", d, 32'h0);
    bus(4'hA, 32'h8, 1, 0, 0, 4'h0, c, d); check("R2 dw2", d, 32'h07800001);
    bus(4'hA, 32'hC, 1, 0, 1, 4'h0, c, d); check("R2 dw3", d, 32'h00001008);
    bus(4'hA, 32'h10, 1, 0, 0, 4'h0, c, d); check("R3 claim", c, 1); check("R3 zero", d, 32'h0);
    bus(4'hA, 32'h40, 1, 0, 0, 4'h0, c, d); check("R3 zero high", d, 32'h0);
  endtask

  task automatic t_cfg_reject();
    logic c; logic [31:0] d;
    bus(4'hA, 32'h0, 0, 0, 0, 4'h0, c, d); check("R4 idsel low", c, 0);
    bus(4'hA, 32'h2, 1, 0, 0, 4'h0, c, d); check("R4 misaligned", c, 0);
  endtask

  task automatic t_io_disabled();
    logic c; logic [31:0] d;
    bus(4'h3, 32'h2000, 0, 32'h1, 0, 4'h0, c, d); check("R6 no claim", c, 0);
    repeat (2) @(negedge clk); #1; check("R6 led unchanged", led, 0);
  endtask

  task automatic t_enable();
    logic c; logic [31:0] d;
    bus(4'hB, 32'h4, 1, 32'h1, 0, 4'h1, c, d); check("R5 be0 off claim", c, 1);
    bus(4'hA, 32'h4, 1, 0, 0, 4'h0, c, d); check("R5 be0 off no store", d, 32'h0);
    bus(4'hB, 32'h8, 1, 32'h1, 0, 4'h0, c, d); check("R5 other dw claim", c, 1);
    bus(4'hB, 32'h4, 1, 32'h1, 2, 4'h0, c, d); check("R5 write claim", c, 1);
    bus(4'hA, 32'h4, 1, 0, 0, 4'h0, c, d); check("R5 readback", d, 32'h1);
  endtask

  task automatic t_io();
    logic c; logic [31:0] d;
    bus(4'h3, 32'h2000, 0, 32'hA5A5_0001, 0, 4'h0, c, d);
    check("R7 claim", c, 1); check("R7 led not yet", led, 0);
    @(negedge clk); #1; check("R7 led follows", led, 1);
    bus(4'h2, 32'h2000, 0, 0, 3, 4'h0, c, d); check("R8 read", d, 32'hA5A5_0001);
    check("R10 claimed after waits", c, 1);
    bus(4'h3, 32'h2004, 0, 32'h0, 0, 4'h0, c, d); check("R9 addr mismatch", c, 0);
    bus(4'h7, 32'h2000, 0, 32'h0, 0, 4'h0, c, d); check("R9 bad cmd", c, 0);
    bus(4'h2, 32'h2000, 0, 0, 0, 4'h0, c, d); check("R9 reg unchanged", d, 32'hA5A5_0001);
    check("R9 led unchanged", led, 1);
    bus(4'h3, 32'h2000, 0, 32'h0, 1, 4'h0, c, d);
    @(negedge clk); #1; check("R7 led clears", led, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_header();
    t_cfg_reject();
    t_io_disabled();
    t_enable();
    t_io();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule